// File: doc/BRIEF.md
# Wiper register I2C controller

This block is the bus side of a 128-step digital potentiometer. An I2C controller on the board talks to it through open-drain SCL and SDA. The block keeps two 7-bit wiper values. The first is a working register that drives the wiper output directly. The second is a persistent copy that the working register is loaded from at power-up. A one-byte selection register, at register address 02h, decides which of the two register address 00h refers to.

A write to address 00h while the working register is selected takes effect at once. A write while the persistent copy is selected updates both registers when the Stop arrives. The block then starts a store period whose length is set by a parameter in clock cycles, and a busy output is high for that period. During the store the block does not respond to the bus at all. Reads set the register pointer with a write, then use a repeated Start and the read address. The target shifts out one byte, most significant bit first, with bit 7 of a wiper value always 0.

SCL and SDA are sampled by the system clock through a synchroniser. Start and Stop are seen as SDA edges while SCL is high. Acknowledge and data bits are driven or released only after a falling SCL edge has been detected.

Top module: `wiper_i2c_ctrl`

## Requirements
- R1: After reset the wiper output equals the power-up content of the persistent register (parameter NV_INIT), busy is 0 and sda_oe is 0.
- R2: The address bytes 0x50 (write) and 0x51 (read) are acknowledged by holding SDA low during the ninth clock. Any other address byte is not acknowledged, and the rest of that transaction changes no register.
- R3: While the selection register is not 0x00, a write of a data byte to register 0x00 sets the wiper output to data[6:0] without raising busy.
- R4: The selection register (register 0x02) stores any written byte, resets to 0x01 and reads back unchanged. The value 0x00 maps register 0x00 to the persistent register, and every other value maps it to the working register.
- R5: While the persistent register is selected, a write of a data byte to register 0x00 loads data[6:0] into both registers when the Stop is detected. Busy then stays high for exactly STORE_CYCLES clock cycles.
- R6: While busy is high, sda_oe stays 0, no byte is acknowledged, and bus traffic changes no register.
- R7: A read of register 0x00 returns {0, selected 7-bit register}, MSB first. The pointer is set by a write transaction, followed by a repeated Start with 0x51.
- R8: Reading the persistent register does not change the wiper output.
- R9: Register addresses other than 0x00 and 0x02 are not acknowledged, and the data byte that follows them is ignored.
- R10: A persistent-register write that is ended by a repeated Start instead of a Stop is discarded: busy does not rise and neither register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low power-on reset |
| scl_i | input | 1 | Bus clock as seen on the pad |
| sda_i | input | 1 | Bus data as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| sda_o | output | 1 | Value driven when enabled, always 0 |
| wiper | output | 7 | Current wiper position (working register) |
| busy | output | 1 | High while a persistent store is running |

## Verification
A corrupted protocol state shows at the ports within one byte. It appears as a missing or misplaced acknowledge, or as a wrong bit order in the read byte, which the bench samples on every ninth clock and on every read. A wrong register value appears on the wiper output right after the transaction that should set it, or in the byte returned by the next read. A wrong selection or pending-store state appears as busy rising when it should not, or staying low when it should rise. A store counter that is off by one is caught when busy falls, because the bench counts the busy cycles.

// File: rtl/wiper_i2c_pkg.sv
`timescale 1ns/1ps
package wiper_i2c_pkg;

    localparam int WIPER_W = 7;
    localparam logic [7:0] REG_WIPER  = 8'h00;
    localparam logic [7:0] REG_SELECT = 8'h02;
    localparam logic [7:0] SEL_RESET  = 8'h01;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK,
        PH_TX
    } phase_e;

    typedef enum logic [1:0] {
        BY_ADDR,
        BY_REG,
        BY_DATA
    } byte_e;

    typedef struct packed {
        phase_e               ph;
        byte_e                which;
        logic [3:0]           cnt;
        logic [7:0]           sh;
        logic                 rd;
        logic [7:0]           ptr;
        logic                 oe;
        logic [7:0]           sel;
        logic [WIPER_W-1:0]   wcr;
        logic [WIPER_W-1:0]   nvr;
        logic                 pend;
        logic [WIPER_W-1:0]   pend_val;
    } ctrl_t;

endpackage

// File: rtl/wiper_i2c_sync.sv
`timescale 1ns/1ps
module wiper_i2c_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic start,
    output logic stop,
    output logic scl_rise,
    output logic scl_fall
);
    localparam int unsigned N = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    logic [N-1:0] scl_chain_d, scl_chain_q;
    logic [N-1:0] sda_chain_d, sda_chain_q;
    logic         scl_p_d, scl_p_q;
    logic         sda_p_d, sda_p_q;

    always_comb begin
        scl_chain_d = {scl_chain_q[N-2:0], scl_i};
        sda_chain_d = {sda_chain_q[N-2:0], sda_i};
        scl_p_d     = scl_chain_q[N-1];
        sda_p_d     = sda_chain_q[N-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_chain_q <= '1;
            sda_chain_q <= '1;
            scl_p_q     <= 1'b1;
            sda_p_q     <= 1'b1;
        end else begin
            scl_chain_q <= scl_chain_d;
            sda_chain_q <= sda_chain_d;
            scl_p_q     <= scl_p_d;
            sda_p_q     <= sda_p_d;
        end
    end

    assign scl_s    = scl_chain_q[N-1];
    assign sda_s    = sda_chain_q[N-1];
    assign start    = scl_s && scl_p_q && sda_p_q && !sda_s;
    assign stop     = scl_s && scl_p_q && !sda_p_q && sda_s;
    assign scl_rise = scl_s && !scl_p_q;
    assign scl_fall = !scl_s && scl_p_q;

endmodule

// File: rtl/wiper_store_timer.sv
`timescale 1ns/1ps
module wiper_store_timer #(
    parameter int unsigned STORE_CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy
);
    localparam int unsigned CW = $clog2(STORE_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (go)
            cnt_d = CW'(STORE_CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/wiper_i2c_fsm.sv
`timescale 1ns/1ps
module wiper_i2c_fsm
    import wiper_i2c_pkg::*;
#(
    parameter logic [6:0]         DEV_ADDR = 7'h28,
    parameter logic [WIPER_W-1:0] NV_INIT  = 7'h40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               stop,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               sda_s,
    input  logic               busy,
    output logic               sda_oe,
    output logic [WIPER_W-1:0] wiper,
    output logic               nv_go
);
    ctrl_t d, q;

    always_comb begin
        logic       ok;
        logic       sel_nv;
        logic [7:0] rbyte;
        d      = q;
        nv_go  = 1'b0;
        ok     = 1'b0;
        sel_nv = (q.sel == 8'h00);
        rbyte  = (q.ptr == REG_SELECT) ? q.sel
                                       : {1'b0, (sel_nv ? q.nvr : q.wcr)};
        if (busy) begin
            d.ph = PH_IDLE;
            d.oe = 1'b0;
        end else if (start) begin
            d.ph    = PH_RX;
            d.which = BY_ADDR;
            d.cnt   = '0;
            d.oe    = 1'b0;
            d.pend  = 1'b0;
        end else if (stop) begin
            d.ph = PH_IDLE;
            d.oe = 1'b0;
            if (q.pend) begin
                d.nvr  = q.pend_val;
                d.wcr  = q.pend_val;
                d.pend = 1'b0;
                nv_go  = 1'b1;
            end
        end else begin
            unique case (q.ph)
                PH_RX: begin
                    if (scl_rise && q.cnt < 4'd8) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        unique case (q.which)
                            BY_ADDR: begin
                                ok   = (q.sh[7:1] == DEV_ADDR);
                                d.rd = q.sh[0];
                            end
                            BY_REG: begin
                                ok    = (q.sh == REG_WIPER) || (q.sh == REG_SELECT);
                                d.ptr = ok ? q.sh : q.ptr;
                            end
                            default: begin
                                ok = 1'b1;
                                if (q.ptr == REG_SELECT)
                                    d.sel = q.sh;
                                else if (sel_nv) begin
                                    d.pend     = 1'b1;
                                    d.pend_val = q.sh[WIPER_W-1:0];
                                end else
                                    d.wcr = q.sh[WIPER_W-1:0];
                            end
                        endcase
                        d.ph = ok ? PH_ACK : PH_IDLE;
                        d.oe = ok;
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        if (q.which == BY_ADDR && q.rd) begin
                            d.ph  = PH_TX;
                            d.sh  = rbyte;
                            d.oe  = ~rbyte[7];
                            d.cnt = 4'd1;
                        end else if (q.which == BY_ADDR) begin
                            d.which = BY_REG;
                            d.ph    = PH_RX;
                        end else if (q.which == BY_REG) begin
                            d.which = BY_DATA;
                            d.ph    = PH_RX;
                        end else begin
                            d.ph = PH_IDLE;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (q.cnt < 4'd8) begin
                            d.oe  = ~q.sh[6];
                            d.sh  = {q.sh[6:0], 1'b0};
                            d.cnt = q.cnt + 4'd1;
                        end else begin
                            d.oe = 1'b0;
                            d.ph = PH_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ph       <= PH_IDLE;
            q.which    <= BY_ADDR;
            q.cnt      <= '0;
            q.sh       <= '0;
            q.rd       <= 1'b0;
            q.ptr      <= REG_WIPER;
            q.oe       <= 1'b0;
            q.sel      <= SEL_RESET;
            q.wcr      <= NV_INIT;
            q.nvr      <= NV_INIT;
            q.pend     <= 1'b0;
            q.pend_val <= '0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;
    assign wiper  = q.wcr;

endmodule

// File: rtl/wiper_i2c_ctrl.sv
`timescale 1ns/1ps
module wiper_i2c_ctrl #(
    parameter logic [6:0]  DEV_ADDR     = 7'h28,
    parameter logic [6:0]  NV_INIT      = 7'h40,
    parameter int unsigned STORE_CYCLES = 1250000,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic       sda_o,
    output logic [6:0] wiper,
    output logic       busy
);
    logic scl_s, sda_s, start, stop, scl_rise, scl_fall, nv_go;

    wiper_i2c_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .start    (start),
        .stop     (stop),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    wiper_i2c_fsm #(.DEV_ADDR(DEV_ADDR), .NV_INIT(NV_INIT)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .stop     (stop),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_s    (sda_s),
        .busy     (busy),
        .sda_oe   (sda_oe),
        .wiper    (wiper),
        .nv_go    (nv_go)
    );

    wiper_store_timer #(.STORE_CYCLES(STORE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (nv_go),
        .busy  (busy)
    );

    assign sda_o = 1'b0;

endmodule

// File: rtl/wiper_i2c_checker.sv
`timescale 1ns/1ps
module wiper_i2c_checker #(
    parameter int unsigned STORE_CYCLES = 1250000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       sda_oe,
    input logic       scl_s,
    input logic [6:0] wiper
);
    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 32'd1;
        else           run_q <= '0;
    end

    a_r5_store_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == STORE_CYCLES));

    a_r5_wiper_frozen_in_store: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(wiper));

    a_r6_released_in_store: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    a_r2_drive_changes_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

endmodule

bind wiper_i2c_ctrl wiper_i2c_checker #(.STORE_CYCLES(STORE_CYCLES)) u_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .sda_oe (sda_oe),
    .scl_s  (scl_s),
    .wiper  (wiper)
);

// File: tb/wiper_i2c_ctrl_bench.sv
`timescale 1ns/1ps
module wiper_i2c_ctrl_bench;
    localparam int unsigned SC = 2000;
    localparam int Q = 8;
    localparam logic [6:0] INIT = 7'h40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe, sda_o, busy;
    logic [6:0] wiper;
    logic sda_line;

    assign sda_line = sda_oe ? sda_o : m_sda;

    always #2 clk = ~clk;

    wiper_i2c_ctrl #(.NV_INIT(INIT), .STORE_CYCLES(SC)) u_wiper_i2c_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .sda_o(sda_o), .wiper(wiper), .busy(busy)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int busy_run = 0;
    logic busy_prev = 1'b0;

    logic [6:0] exp_wcr = INIT;
    logic [6:0] exp_nvr = INIT;
    logic [7:0] exp_sel = 8'h01;

    always @(negedge clk) begin
        if (busy && !busy_prev) busy_run = 1;
        else if (busy)          busy_run = busy_run + 1;
        busy_prev = busy;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wclk(Q); scl = 1'b1; wclk(Q);
        m_sda = 1'b0; wclk(Q); scl = 1'b0; wclk(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wclk(Q); scl = 1'b1; wclk(Q); m_sda = 1'b1; wclk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wclk(Q); scl = 1'b1; wclk(Q); scl = 1'b0;
        end
        m_sda = 1'b1; wclk(Q); scl = 1'b1; wclk(Q / 2);
        ack = ~sda_line;
        wclk(Q / 2); scl = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; wclk(Q); scl = 1'b1; wclk(Q / 2);
            b[i] = sda_line;
            wclk(Q / 2); scl = 1'b0;
        end
        m_sda = 1'b1; wclk(Q); scl = 1'b1; wclk(Q); scl = 1'b0;
    endtask

    task automatic write_txn(input logic [7:0] dev, input logic [7:0] rg,
                             input logic [7:0] dat, output logic [2:0] acks);
        logic a;
        bus_start();
        send_byte(dev, a); acks[2] = a;
        send_byte(rg,  a); acks[1] = a;
        send_byte(dat, a); acks[0] = a;
        bus_stop();
    endtask

    task automatic read_txn(input logic [7:0] rg, output logic [7:0] val,
                            output logic [2:0] acks);
        logic a;
        bus_start();
        send_byte(8'h50, a); acks[2] = a;
        send_byte(rg,    a); acks[1] = a;
        bus_start();
        send_byte(8'h51, a); acks[0] = a;
        recv_byte(val);
        bus_stop();
    endtask

    task automatic wait_store();
        for (int i = 0; i < 3 * SC && busy; i++) wclk(1);
        wclk(2);
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] rg);
        if (rg == 8'h02) return exp_sel;
        return {1'b0, (exp_sel == 8'h00) ? exp_nvr : exp_wcr};
    endfunction

    task automatic model_write(input logic [7:0] rg, input logic [7:0] dat, input string req);
        logic [2:0] acks;
        logic nv;
        nv = (rg == 8'h00) && (exp_sel == 8'h00);
        write_txn(8'h50, rg, dat, acks);
        check({req, " acks"}, acks, 3'b111);
        if (rg == 8'h02) exp_sel = dat;
        else if (nv) begin exp_wcr = dat[6:0]; exp_nvr = dat[6:0]; end
        else exp_wcr = dat[6:0];
        check({req, " busy"}, busy, nv);
        if (nv) begin
            wait_store();
            check("R5 store length", busy_run, SC);
        end
        check({req, " wiper"}, wiper, exp_wcr);
    endtask

    task automatic model_read_chk(input logic [7:0] rg, input string req);
        logic [7:0] v;
        logic [2:0] acks;
        read_txn(rg, v, acks);
        check({req, " read acks"}, acks, 3'b111);
        check({req, " read data"}, v, model_read(rg));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [2:0] acks;
        logic [7:0] v;
        void'($urandom(32'd5132));
        wclk(5);
        rst_n = 1'b1;
        wclk(3);
        // R1 reset state
        check("R1 wiper", wiper, INIT);
        check("R1 busy", busy, 0);
        check("R1 sda_oe", sda_oe, 0);

        // R7 read working register, R2 acks of both addresses
        model_read_chk(8'h00, "R7 R2");
        // R3 immediate working write
        model_write(8'h00, 8'hD5, "R3");
        check("R3 no busy", busy_run, 0);

        // R2 foreign address ignored
        write_txn(8'h52, 8'h00, 8'h11, acks);
        check("R2 foreign acks", acks, 3'b000);
        check("R2 foreign wiper", wiper, exp_wcr);

        // R9 unsupported register
        write_txn(8'h50, 8'h05, 8'h22, acks);
        check("R9 acks", acks, 3'b100);
        check("R9 wiper", wiper, exp_wcr);

        // R4 select persistent, read back selection
        model_write(8'h02, 8'h00, "R4");
        model_read_chk(8'h02, "R4");
        // R8 reading persistent register leaves wiper
        model_read_chk(8'h00, "R8 R7");
        check("R8 wiper", wiper, 7'h55);

        // R10 write cut by repeated start is dropped
        bus_start();
        send_byte(8'h50, acks[2]); send_byte(8'h00, acks[1]); send_byte(8'h33, acks[0]);
        bus_start();
        bus_stop();
        wclk(4);
        check("R10 busy", busy, 0);
        check("R10 wiper", wiper, exp_wcr);
        model_read_chk(8'h00, "R10");

        // R5 persistent write
        model_write(8'h00, 8'h9A, "R5");
        model_read_chk(8'h00, "R5 R7");

        // R6 traffic during store
        write_txn(8'h50, 8'h00, 8'h77, acks);
        check("R5 busy after store write", busy, 1);
        exp_wcr = 7'h77; exp_nvr = 7'h77;
        write_txn(8'h50, 8'h02, 8'h01, acks);
        check("R6 acks while busy", acks, 3'b000);
        check("R6 busy still", busy, 1);
        wait_store();
        check("R6 store length", busy_run, SC);
        model_read_chk(8'h02, "R6 selection kept");
        check("R6 wiper", wiper, 7'h77);

        // R4 nonzero selection maps back to working register
        model_write(8'h02, 8'h37, "R4 nonzero");
        model_read_chk(8'h02, "R4");
        model_write(8'h00, 8'h0C, "R3 second");

        // random mix
        for (int n = 0; n < 24; n++) begin
            int op;
            logic [7:0] r;
            op = int'($urandom % 3);
            r  = 8'($urandom);
            if (op == 0) model_write(8'h02, ($urandom % 2) ? 8'h00 : r, "R4 random");
            else if (op == 1) model_write(8'h00, r, "R3 R5 random");
            else model_read_chk(($urandom % 2) ? 8'h02 : 8'h00, "R7 random");
            check("R8 random wiper", wiper, exp_wcr);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule